// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the host-side engine that runs write and erase operations on a parallel NOR flash part. A client sets a two-bit operation code, a target address and a data word, then raises a request while the block is idle. The block drives the command writes the flash expects, one bus write per command word. A word program needs three unlock writes followed by the user write. The three erase kinds share a five-write prefix and then issue a final command write that depends on the kind. Each bus write has fixed phases, all counted in clock cycles: setup, strobe low, hold and gap.

After the last write, the block polls the part with status reads at the target address. The operation is complete once two consecutive reads agree on the toggling status bits. The block then returns a one-cycle acknowledge with an error flag. The flag is set only when the read budget runs out before the status settles.

Top module: `nor_prog_seq`

## Requirements
- R1: While reset is applied and right after it, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, `fl_dq_oe` is 0, `ack` is 0, and `req_ready` is 1 once reset has been released.
- R2: Operation code 0 (word program) produces exactly four bus writes: 0x00AA at 0x5555, 0x0055 at 0x2AAA, 0x00A0 at 0x5555, then `req_data` at `req_addr`.
- R3: Operation codes 1, 2 and 3 (erase kinds) each produce exactly six bus writes. The first five are 0x00AA at 0x5555, 0x0055 at 0x2AAA, 0x0080 at 0x5555, 0x00AA at 0x5555 and 0x0055 at 0x2AAA.
- R4: The sixth erase write depends on the code. Code 1 (whole chip) writes 0x0010 at 0x5555, code 2 (block) writes 0x0050 at `req_addr`, and code 3 (sector) writes 0x0030 at `req_addr`.
- R5: In every bus write, `fl_we_n` stays low for exactly `T_WL` cycles. Throughout that time `fl_ce_n` is 0, `fl_dq_oe` is 1 and `fl_addr` does not change. The data is taken on the cycle after `fl_we_n` rises.
- R6: `fl_dq_oe` is never 1 while `fl_oe_n` is 0, `fl_oe_n` and `fl_we_n` are never low together, and `fl_ce_n` is 0 during every read.
- R7: Polling reads `fl_dq_in` until two consecutive reads are equal under `STAT_MASK`, which by default keeps bits 6 and 2 only. It always makes at least two reads, other bits have no effect, and it then acknowledges with `ack_err` = 0.
- R8: If `POLL_MAX` reads have been made and the last two of them still differ under the mask, the block acknowledges with `ack_err` = 1. A match on read number `POLL_MAX` still counts as success.
- R9: `req_ready` is 0 from the cycle after acceptance until the acknowledge. A request raised in that time is ignored: no extra write, no second acknowledge.
- R10: `ack` is a single-cycle pulse, due `T_RGAP` cycles after `fl_oe_n` rises at the end of the last read. `ack_err` is 1 only together with `ack`, and `req_ready` is 1 again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 program, 1 chip erase, 2 block erase, 3 sector erase |
| req_addr | input | AW | Target word, block or sector address |
| req_data | input | DW | Word to program |
| req_ready | output | 1 | High while idle |
| ack | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Poll budget exhausted, valid with ack |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for the flash data bus |
| fl_dq_in | input | DW | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
Every result has a fixed cycle position that follows from the phase parameters. An address is valid on the first cycle of a strobe-low window, and a data word on the first cycle after the strobe rises. The acknowledge comes exactly `T_RGAP` cycles after the last read releases `fl_oe_n`. The bench samples on the falling clock edge, so it reads each value inside the cycle the requirement names. It counts strobe-low widths and the cycles from read end to acknowledge, and compares them for equality rather than waiting loosely. The flash model toggles the status bits for a chosen number of reads, so the expected read count (the larger of 2 and busy+1, capped at `POLL_MAX`) is known before each request.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_CHIP  = 2'd1,
    OP_BLOCK = 2'd2,
    OP_SECT  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SU   = 3'd1,
    PH_LOW  = 3'd2,
    PH_HOLD = 3'd3,
    PH_GAP  = 3'd4,
    PH_RD   = 3'd5,
    PH_RGAP = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_POLL  = 2'd2,
    ST_ACK   = 2'd3
  } state_e;

  localparam int STEP_W = 3;

endpackage

// File: rtl/nps_cmd_step.sv
module nps_cmd_step
  import nps_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  op_e                 op,
  input  logic [STEP_W-1:0]   step,
  input  logic [AW-1:0]       usr_addr,
  input  logic [DW-1:0]       usr_data,
  output logic [AW-1:0]       addr,
  output logic [DW-1:0]       data,
  output logic                last
);

  localparam logic [AW-1:0] ADR_X = AW'(16'h5555);
  localparam logic [AW-1:0] ADR_Y = AW'(16'h2AAA);

  // command words carry a zero upper byte
  function automatic logic [DW-1:0] cw(input logic [7:0] b);
    return DW'(b);
  endfunction

  always_comb begin
    addr = ADR_X;
    data = cw(8'hAA);
    last = 1'b0;
    if (op == OP_PROG) begin
      case (step)
        3'd0: begin addr = ADR_X; data = cw(8'hAA); end
        3'd1: begin addr = ADR_Y; data = cw(8'h55); end
        3'd2: begin addr = ADR_X; data = cw(8'hA0); end
        default: begin
          addr = usr_addr;
          data = usr_data;
          last = 1'b1;
        end
      endcase
    end else begin
      case (step)
        3'd0: begin addr = ADR_X; data = cw(8'hAA); end
        3'd1: begin addr = ADR_Y; data = cw(8'h55); end
        3'd2: begin addr = ADR_X; data = cw(8'h80); end
        3'd3: begin addr = ADR_X; data = cw(8'hAA); end
        3'd4: begin addr = ADR_Y; data = cw(8'h55); end
        default: begin
          last = 1'b1;
          case (op)
            OP_CHIP:  begin addr = ADR_X;    data = cw(8'h10); end
            OP_BLOCK: begin addr = usr_addr; data = cw(8'h50); end
            default:  begin addr = usr_addr; data = cw(8'h30); end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/nps_bus_timer.sv
module nps_bus_timer
  import nps_pkg::*;
#(
  parameter int T_SU   = 1,
  parameter int T_WL   = 2,
  parameter int T_HD   = 1,
  parameter int T_GAP  = 2,
  parameter int T_RD   = 2,
  parameter int T_RGAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic start_rd,
  output logic idle,
  output logic done,
  output logic sample,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);

  localparam int M1   = (T_SU > T_WL) ? T_SU : T_WL;
  localparam int M2   = (T_HD > T_GAP) ? T_HD : T_GAP;
  localparam int M3   = (T_RD > T_RGAP) ? T_RD : T_RGAP;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M12 > M3) ? M12 : M3;
  localparam int CW   = (MAXT < 2) ? 1 : $clog2(MAXT);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;
  logic          at_end;

  always_comb begin
    case (phase_q)
      PH_SU:   lim = CW'(T_SU - 1);
      PH_LOW:  lim = CW'(T_WL - 1);
      PH_HOLD: lim = CW'(T_HD - 1);
      PH_GAP:  lim = CW'(T_GAP - 1);
      PH_RD:   lim = CW'(T_RD - 1);
      PH_RGAP: lim = CW'(T_RGAP - 1);
      default: lim = '0;
    endcase
  end

  assign at_end = (phase_q != PH_IDLE) && (cnt_q == lim);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (phase_q == PH_IDLE) begin
      cnt_d = '0;
      if (start_wr)      phase_d = PH_SU;
      else if (start_rd) phase_d = PH_RD;
    end else if (at_end) begin
      cnt_d = '0;
      case (phase_q)
        PH_SU:   phase_d = PH_LOW;
        PH_LOW:  phase_d = PH_HOLD;
        PH_HOLD: phase_d = PH_GAP;
        PH_RD:   phase_d = PH_RGAP;
        default: phase_d = PH_IDLE;
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign idle   = (phase_q == PH_IDLE);
  assign done   = at_end && ((phase_q == PH_GAP) || (phase_q == PH_RGAP));
  assign sample = at_end && (phase_q == PH_RD);
  assign we_n   = !(phase_q == PH_LOW);
  assign oe_n   = !(phase_q == PH_RD);
  assign dq_oe  = (phase_q == PH_SU) || (phase_q == PH_LOW) || (phase_q == PH_HOLD);
  assign ce_n   = !(dq_oe || (phase_q == PH_RD));

  // R5: a strobe-low window is always entered from setup
  a_r5_low_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(phase_q) == PH_SU);

endmodule

// File: rtl/nps_poll.sv
module nps_poll #(
  parameter int              DW        = 16,
  parameter int              POLL_MAX  = 1024,
  parameter logic [DW-1:0]   STAT_MASK = 16'h0044
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic [DW-1:0] dq_in,
  output logic          ok,
  output logic          expired
);

  localparam int PW = $clog2(POLL_MAX + 1);

  logic [DW-1:0] cur_q, cur_d, prev_q, prev_d;
  logic [PW-1:0] n_q, n_d;

  always_comb begin
    cur_d  = cur_q;
    prev_d = prev_q;
    n_d    = n_q;
    if (clear) begin
      n_d = '0;
    end else if (sample) begin
      prev_d = cur_q;
      cur_d  = dq_in;
      n_d    = (n_q == PW'(POLL_MAX)) ? n_q : n_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      n_q    <= '0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
      n_q    <= n_d;
    end
  end

  assign ok      = (n_q >= PW'(2)) && (((cur_q ^ prev_q) & STAT_MASK) == '0);
  assign expired = (n_q >= PW'(POLL_MAX));

  // R8: read count never passes its budget
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= PW'(POLL_MAX));

  // R7: a fresh operation starts its comparison from scratch
  a_r7_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (n_q == '0));

endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
  import nps_pkg::*;
#(
  parameter int            AW        = 21,
  parameter int            DW        = 16,
  parameter int            T_SU      = 1,
  parameter int            T_WL      = 2,
  parameter int            T_HD      = 1,
  parameter int            T_GAP     = 2,
  parameter int            T_RD      = 2,
  parameter int            T_RGAP    = 1,
  parameter int            POLL_MAX  = 1024,
  parameter logic [DW-1:0] STAT_MASK = 16'h0044
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  output logic          ack,
  output logic          ack_err,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  state_e            state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  op_e               op_q, op_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [DW-1:0]     data_q, data_d;
  logic              err_q, err_d;
  logic              load_req;

  logic              start_wr, start_rd;
  logic              tmr_idle, tmr_done, tmr_sample;
  logic              poll_ok, poll_expired;
  logic [AW-1:0]     cmd_addr;
  logic [DW-1:0]     cmd_data;
  logic              cmd_last;

  nps_cmd_step #(.AW(AW), .DW(DW)) u_cmd (
    .op       (op_q),
    .step     (step_q),
    .usr_addr (addr_q),
    .usr_data (data_q),
    .addr     (cmd_addr),
    .data     (cmd_data),
    .last     (cmd_last)
  );

  nps_bus_timer #(
    .T_SU(T_SU), .T_WL(T_WL), .T_HD(T_HD),
    .T_GAP(T_GAP), .T_RD(T_RD), .T_RGAP(T_RGAP)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start_wr (start_wr),
    .start_rd (start_rd),
    .idle     (tmr_idle),
    .done     (tmr_done),
    .sample   (tmr_sample),
    .ce_n     (fl_ce_n),
    .we_n     (fl_we_n),
    .oe_n     (fl_oe_n),
    .dq_oe    (fl_dq_oe)
  );

  nps_poll #(.DW(DW), .POLL_MAX(POLL_MAX), .STAT_MASK(STAT_MASK)) u_poll (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clear   (state_q == ST_IDLE),
    .sample  (tmr_sample),
    .dq_in   (fl_dq_in),
    .ok      (poll_ok),
    .expired (poll_expired)
  );

  // next-state
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    err_d    = err_q;
    load_req = 1'b0;
    start_wr = 1'b0;
    start_rd = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load_req = 1'b1;
          step_d   = '0;
          err_d    = 1'b0;
          state_d  = ST_WRITE;
        end
      end
      ST_WRITE: begin
        start_wr = tmr_idle;
        if (tmr_done) begin
          if (cmd_last) state_d = ST_POLL;
          else          step_d  = step_q + 1'b1;
        end
      end
      ST_POLL: begin
        start_rd = tmr_idle;
        if (tmr_done) begin
          if (poll_ok) begin
            state_d = ST_ACK;
          end else if (poll_expired) begin
            state_d = ST_ACK;
            err_d   = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign op_d   = load_req ? op_e'(req_op) : op_q;
  assign addr_d = load_req ? req_addr : addr_q;
  assign data_d = load_req ? req_data : data_q;

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      err_q   <= 1'b0;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      err_q   <= err_d;
      if (load_req) begin
        op_q   <= op_d;
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ack       = (state_q == ST_ACK);
  assign ack_err   = (state_q == ST_ACK) && err_q;
  assign fl_addr   = (state_q == ST_WRITE) ? cmd_addr : addr_q;
  assign fl_dq_out = cmd_data;

  // R6: never drive the data bus while the flash drives it
  a_r6_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(fl_dq_oe && !fl_oe_n));

  // R6: read and write strobes exclusive
  a_r6_strobes_excl: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(!fl_oe_n && !fl_we_n));

  // R5: chip enable covers the write strobe
  a_r5_ce_covers_we: assert property (@(posedge clk) disable iff (!rst_i_n)
    !fl_we_n |-> !fl_ce_n);

  // R5: address steady while the strobe is low
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_addr));

  // R10: acknowledge lasts one cycle
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    ack |=> !ack);

  // R10: error flag only with the acknowledge
  a_r10_err_with_ack: assert property (@(posedge clk) disable iff (!rst_i_n)
    ack_err |-> ack);

  // R9: no new acceptance while busy
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != ST_IDLE) |-> !req_ready);

endmodule

// File: tb/nor_prog_seq_bench.sv
module nor_prog_seq_bench;

  localparam int AW = 21;
  localparam int DW = 16;
  localparam int T_WL = 2;
  localparam int T_RGAP = 1;
  localparam int PMAX = 16;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          req_ready, ack, ack_err;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out, fl_dq_in;
  logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  nor_prog_seq #(.AW(AW), .DW(DW), .T_WL(T_WL), .T_RGAP(T_RGAP), .POLL_MAX(PMAX)) u_nor_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
    .ack(ack), .ack_err(ack_err), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchk = 0;
  int nbad = 0;

  task automatic chk(input bit c, input string r, input longint act, input longint exp);
    nchk++;
    if (!c) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // flash model and bus monitor
  logic          tgl = 1'b0;
  logic          noise = 1'b0;
  int            busy_left = 0;
  logic [AW-1:0] wa [8];
  logic [DW-1:0] wd [8];
  int            nwr = 0, nrd = 0, nack = 0, viol = 0, since = 0, wlow = 0;
  logic          last_err = 1'b0;
  logic [AW-1:0] fall_addr = '0;
  logic          we_prev = 1'b1, oe_prev = 1'b1, ack_prev = 1'b0;

  assign fl_dq_in = {9'h000, tgl, noise, 2'b00, tgl, 2'b00};

  always @(negedge clk) begin
    if (we_prev && !fl_we_n) begin
      fall_addr = fl_addr;
      wlow = 1;
    end else if (!fl_we_n) begin
      wlow++;
    end
    if (!fl_we_n && (fl_ce_n || !fl_dq_oe || fl_addr != fall_addr)) viol++;
    if (!we_prev && fl_we_n) begin
      if (nwr < 8) begin
        wa[nwr] = fall_addr;
        wd[nwr] = fl_dq_out;
      end
      chk(wlow == T_WL, "R5 strobe low width", wlow, T_WL);
      nwr++;
    end
    if (!fl_oe_n && (fl_dq_oe || fl_ce_n || !fl_we_n)) viol++;
    if (oe_prev && !fl_oe_n) begin
      nrd++;
      noise = ~noise;
      if (busy_left > 0) begin
        tgl = ~tgl;
        busy_left--;
      end
    end
    if (!oe_prev && fl_oe_n) since = 0;
    else since++;
    if (ack) begin
      nack++;
      last_err = ack_err;
      chk(since == T_RGAP, "R10 ack timing", since, T_RGAP);
      if (ack_prev) viol++;
    end
    if (ack_err && !ack) viol++;
    we_prev  = fl_we_n;
    oe_prev  = fl_oe_n;
    ack_prev = ack;
  end

  // watchdog
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int b, input bit try_busy);
    logic [AW-1:0] ea [8];
    logic [DW-1:0] ed [8];
    int ne, er, n;
    bit ee;
    nwr = 0; nrd = 0; nack = 0; viol = 0; busy_left = b;
    ea[0] = 21'h5555; ed[0] = 16'h00AA;
    ea[1] = 21'h2AAA; ed[1] = 16'h0055;
    if (op == 0) begin
      ea[2] = 21'h5555; ed[2] = 16'h00A0;
      ea[3] = a;        ed[3] = d;
      ne = 4;
    end else begin
      ea[2] = 21'h5555; ed[2] = 16'h0080;
      ea[3] = 21'h5555; ed[3] = 16'h00AA;
      ea[4] = 21'h2AAA; ed[4] = 16'h0055;
      if (op == 1)      begin ea[5] = 21'h5555; ed[5] = 16'h0010; end
      else if (op == 2) begin ea[5] = a;        ed[5] = 16'h0050; end
      else              begin ea[5] = a;        ed[5] = 16'h0030; end
      ne = 6;
    end
    er = (b + 1 > 2) ? b + 1 : 2;
    ee = 1'b0;
    if (er > PMAX) begin er = PMAX; ee = 1'b1; end

    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 ready low after accept", req_ready, 0);
    if (try_busy) begin
      repeat (4) @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_addr = 21'h00777; req_data = 16'h1234;
      repeat (20) @(negedge clk);
      chk(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
      req_valid = 1'b0;
    end
    n = 0;
    while (nack == 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (12) @(negedge clk);

    chk(nwr == ne, (op == 0) ? "R2 write count" : "R3 write count", nwr, ne);
    for (int i = 0; i < ne && i < nwr; i++) begin
      string tg;
      tg = (op == 0) ? "R2 write" : ((i == 5) ? "R4 final erase write" : "R3 erase prefix");
      chk(wa[i] == ea[i], {tg, " addr"}, wa[i], ea[i]);
      chk(wd[i] == ed[i], {tg, " data"}, wd[i], ed[i]);
    end
    chk(nrd == er, ee ? "R8 read count" : "R7 read count", nrd, er);
    chk(nack == 1, "R10 single ack", nack, 1);
    chk(last_err == ee, ee ? "R8 error flag" : "R7 error flag", last_err, ee);
    chk(viol == 0, "R6 bus rules", viol, 0);
    chk(req_ready == 1'b1, "R10 ready after ack", req_ready, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes idle in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk(fl_dq_oe == 1'b0, "R1 bus released in reset", fl_dq_oe, 0);
    chk(ack == 1'b0, "R1 no ack in reset", ack, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes idle after reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
  endtask

  task automatic t_program;      run_op(0, 21'h1ABCD, 16'hBEEF, 3, 1'b0); endtask
  task automatic t_program_fast; run_op(0, 21'h00010, 16'h0F0F, 0, 1'b0); endtask
  task automatic t_chip;         run_op(1, 21'h0AAAA, 16'h0000, 5, 1'b0); endtask
  task automatic t_block;        run_op(2, 21'h0F000, 16'h0000, 2, 1'b0); endtask
  task automatic t_sector;       run_op(3, 21'h12000, 16'h0000, 1, 1'b0); endtask
  task automatic t_limit_ok;     run_op(0, 21'h1FFFF, 16'h8001, PMAX - 1, 1'b0); endtask
  task automatic t_timeout;      run_op(3, 21'h04000, 16'h0000, 100, 1'b0); endtask
  task automatic t_busy_ignore;  run_op(1, 21'h00000, 16'h0000, 2, 1'b1); endtask

  initial begin
    t_reset();
    t_program();
    t_program_fast();
    t_chip();
    t_block();
    t_sector();
    t_limit_ok();
    t_timeout();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule